// File: doc/BRIEF.md
# Validation Coprocessor with Timed Interrupts

This block is a test-support coprocessor that a processor core reaches through its coprocessor port. It answers on two coprocessor numbers, A and B, which share a file of sixteen 32-bit registers. Through either number the core can move a word into or out of any register. Number A also accepts memory load/store commands, whose data beats arrive later as separate handshake inputs, and a single data operation that stalls the core for a programmed number of cycles.

Number B carries the timing features used by validation programs: the same stall, a fast (FIQ) and a normal (IRQ) interrupt request that fire a programmed number of cycles after the command, commands that drop each request again, and a capture of a free-running clock counter into a register. Every count is taken from the register that the low four instruction bits select. Each accepted command or beat is answered one cycle later with a response code and, for reads, a data word. Commands the block does not support are answered "cannot", which the core turns into an undefined-instruction trap.

Top module: `valcop_top`

## Requirements
- R1: Synchronous reset clears resp_valid, drives fiq_n and irq_n high, cancels any pending interrupt countdown and any open load/store transfer, and zeroes the cycle counter.
- R2: With cmd_kind 0 (write to coprocessor) or 1 (read from coprocessor) on either number, the register chosen by instruction bits 19:16 is written with cmd_wdata or returned on resp_rdata; the response (the cycle after the command) is resp_valid high with resp_code 0 (done). Codes are 0 done, 1 increment, 2 busy, 3 cannot.
- R3: A command whose cmd_cp matches neither number gets no response and leaves the register file unchanged.
- R4: cmd_kind 2 (load) or 3 (store) on number A answers done and opens a transfer on the register chosen by bits 15:12; each later beat_valid writes beat_wdata into it (load) or returns it on resp_rdata (store). With bit 22 clear the first beat answers done and closes the transfer.
- R5: With bit 22 set, beats one to four answer increment and the fifth answers done, all on the same register; a beat while no transfer is open gets no response, and a new load/store command restarts the beat count.
- R6: Load or store on number B answers cannot.
- R7: cmd_kind 4 (data operation) with opcode 0 in bits 23:20, on either number, takes a count N from the register chosen by bits 3:0 and answers busy for N consecutive cycles and then done; N of zero answers done at once. Commands arriving during the busy cycles are ignored.
- R8: On number B, opcode 1 drives fiq_n low on the Nth clock edge after the command edge (the command edge itself when N is zero); opcode 2 does the same for irq_n. The two countdowns are independent.
- R9: On number B, opcodes 3 and 4 raise fiq_n and irq_n respectively on the command edge; a countdown still pending fires later. Re-issuing opcode 1 or 2 restarts its countdown.
- R10: On number B, opcode 5 writes the cycle counter, which advances by one every clock from reset, into the register chosen by bits 3:0; two captures issued K cycles apart differ by K.
- R11: Number A answers cannot to opcodes 1 to 15, number B to opcodes 6 to 15, and either number to cmd_kind 5 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_cp | input | 4 | Coprocessor number addressed |
| cmd_kind | input | 3 | 0 write, 1 read, 2 load, 3 store, 4 data operation |
| cmd_instr | input | 32 | Instruction word carrying the field selects |
| cmd_wdata | input | DATA_W | Word written by a write command |
| beat_valid | input | 1 | A load/store data beat is presented |
| beat_wdata | input | DATA_W | Beat word for loads |
| resp_valid | output | 1 | A response is presented |
| resp_code | output | 2 | 0 done, 1 increment, 2 busy, 3 cannot |
| resp_rdata | output | DATA_W | Read or store-beat data |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The bench builds the block at its defaults: sixteen 32-bit registers, five-beat bursts and coprocessor numbers 4 and 5, with 7 used as an unclaimed number. Counts are loaded with small values (zero to five), which brings the zero-count shortcut, the exact edge on which each interrupt line falls, overlapping and restarted countdowns, and the full increment-then-done burst sequence within a few cycles of each command.

// File: rtl/valcop_pkg.sv
package valcop_pkg;

  localparam int unsigned INSTR_W = 32;

  // Instruction field positions decoded by the block
  localparam int unsigned XFER_LSB = 16;
  localparam int unsigned MEM_LSB  = 12;
  localparam int unsigned CNT_LSB  = 0;
  localparam int unsigned OP_LSB   = 20;
  localparam int unsigned LONG_BIT = 22;

  typedef enum logic [2:0] {
    CK_TO_CP   = 3'd0,
    CK_FROM_CP = 3'd1,
    CK_LOAD    = 3'd2,
    CK_STORE   = 3'd3,
    CK_DATAOP  = 3'd4
  } cmd_kind_e;

  typedef enum logic [1:0] {
    RS_DONE = 2'd0,
    RS_INC  = 2'd1,
    RS_BUSY = 2'd2,
    RS_CANT = 2'd3
  } resp_e;

  localparam logic [3:0] OP_WAIT    = 4'd0;
  localparam logic [3:0] OP_FIQ_SET = 4'd1;
  localparam logic [3:0] OP_IRQ_SET = 4'd2;
  localparam logic [3:0] OP_FIQ_CLR = 4'd3;
  localparam logic [3:0] OP_IRQ_CLR = 4'd4;
  localparam logic [3:0] OP_STAMP   = 4'd5;

endpackage

// File: rtl/valcop_regfile.sv
// Shared register file: one write port, two asynchronous read ports
// (transfer data and count operand), small enough for distributed RAM.
module valcop_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/valcop_wait.sv
// Busy-wait engine: after a start with a non-zero count it stays busy
// for that many further cycles; 'last' marks the final busy cycle.
module valcop_wait #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             last
);

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (start && (count != '0)) begin
      busy <= 1'b1;
      left <= count;
    end else if (busy) begin
      left <= left - 1'b1;
      if (left == CNT_W'(1)) begin
        busy <= 1'b0;
      end
    end
  end

  assign last = busy && (left == CNT_W'(1));

endmodule

// File: rtl/valcop_irq_timer.sv
// One delayed interrupt channel: arm loads a countdown (zero fires at
// once), clear raises the line without touching a pending countdown.
module valcop_irq_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [CNT_W-1:0] count,
  input  logic             clear,
  output logic             line_n
);

  logic [CNT_W-1:0] left;
  logic             pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      left    <= '0;
      pending <= 1'b0;
      line_n  <= 1'b1;
    end else begin
      if (arm) begin
        if (count == '0) begin
          pending <= 1'b0;
          line_n  <= 1'b0;
        end else begin
          pending <= 1'b1;
          left    <= count;
        end
      end else if (pending) begin
        left <= left - 1'b1;
        if (left == CNT_W'(1)) begin
          pending <= 1'b0;
          line_n  <= 1'b0;
        end
      end
      if (clear) begin
        line_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/valcop_top.sv
module valcop_top
  import valcop_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned REG_CNT     = 16,
  parameter int unsigned BURST_BEATS = 5,
  parameter logic [3:0]  CP_A        = 4'd4,
  parameter logic [3:0]  CP_B        = 4'd5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_cp,
  input  logic [2:0]         cmd_kind,
  input  logic [INSTR_W-1:0] cmd_instr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic               beat_valid,
  input  logic [DATA_W-1:0]  beat_wdata,
  output logic               resp_valid,
  output logic [1:0]         resp_code,
  output logic [DATA_W-1:0]  resp_rdata,
  output logic               fiq_n,
  output logic               irq_n
);

  localparam int unsigned IDX_W    = $clog2(REG_CNT);
  localparam int unsigned BEAT_W   = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam int unsigned N_TIMERS = 2;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

  // ---------------------------------------------------------------
  // Command decode
  // ---------------------------------------------------------------
  cmd_kind_e        kind;
  logic             hit_a, hit_b, accept;
  logic [3:0]       opcode;
  logic [IDX_W-1:0] xfer_idx, mem_idx, cnt_idx;
  logic             unused_instr;

  assign kind     = cmd_kind_e'(cmd_kind);
  assign hit_a    = (cmd_cp == CP_A);
  assign hit_b    = (cmd_cp == CP_B);
  assign opcode   = cmd_instr[OP_LSB +: 4];
  assign xfer_idx = cmd_instr[XFER_LSB +: IDX_W];
  assign mem_idx  = cmd_instr[MEM_LSB +: IDX_W];
  assign cnt_idx  = cmd_instr[CNT_LSB +: IDX_W];
  assign unused_instr = ^{cmd_instr[31:24], cmd_instr[11:4]};

  // ---------------------------------------------------------------
  // State and internal nets
  // ---------------------------------------------------------------
  logic [DATA_W-1:0]   cyc_cnt;
  logic                wait_busy, wait_last, wait_start;
  logic [N_TIMERS-1:0] t_arm, t_clr, t_line_n;

  logic                rf_we;
  logic [IDX_W-1:0]    rf_waddr, rf_raddr_a;
  logic [DATA_W-1:0]   rf_wdata, rf_rdata_a, count_val;

  logic                ls_open, ls_load, ls_long;
  logic [IDX_W-1:0]    ls_idx;
  logic [BEAT_W-1:0]   beat_cnt;
  logic                ls_set, beat_take, beat_final;

  logic                nx_valid;
  resp_e               nx_code;
  logic [DATA_W-1:0]   nx_rdata;

  assign accept     = cmd_valid && !wait_busy && (hit_a || hit_b);
  assign beat_final = !ls_long || (beat_cnt == LAST_BEAT);

  // ---------------------------------------------------------------
  // Register file
  // ---------------------------------------------------------------
  valcop_regfile #(
    .W    (DATA_W),
    .DEPTH(REG_CNT),
    .AW   (IDX_W)
  ) u_regfile (
    .clk    (clk),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .raddr_a(rf_raddr_a),
    .rdata_a(rf_rdata_a),
    .raddr_b(cnt_idx),
    .rdata_b(count_val)
  );

  // ---------------------------------------------------------------
  // Busy-wait engine and interrupt channels (0 = fast, 1 = normal)
  // ---------------------------------------------------------------
  valcop_wait #(.CNT_W(DATA_W)) u_wait (
    .clk  (clk),
    .rst  (rst),
    .start(wait_start),
    .count(count_val),
    .busy (wait_busy),
    .last (wait_last)
  );

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    valcop_irq_timer #(.CNT_W(DATA_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .arm   (t_arm[g]),
      .count (count_val),
      .clear (t_clr[g]),
      .line_n(t_line_n[g])
    );
  end

  assign fiq_n = t_line_n[0];
  assign irq_n = t_line_n[1];

  // ---------------------------------------------------------------
  // Response and side-effect selection
  // ---------------------------------------------------------------
  always_comb begin
    nx_valid   = 1'b0;
    nx_code    = RS_DONE;
    nx_rdata   = '0;
    rf_we      = 1'b0;
    rf_waddr   = xfer_idx;
    rf_wdata   = cmd_wdata;
    rf_raddr_a = accept ? xfer_idx : ls_idx;
    wait_start = 1'b0;
    t_arm      = '0;
    t_clr      = '0;
    ls_set     = 1'b0;
    beat_take  = 1'b0;

    if (wait_busy) begin
      nx_valid = 1'b1;
      nx_code  = wait_last ? RS_DONE : RS_BUSY;
    end else if (accept) begin
      nx_valid = 1'b1;
      case (kind)
        CK_TO_CP:   rf_we = 1'b1;
        CK_FROM_CP: nx_rdata = rf_rdata_a;
        CK_LOAD, CK_STORE: begin
          if (hit_a) begin
            ls_set = 1'b1;
          end else begin
            nx_code = RS_CANT;
          end
        end
        CK_DATAOP: begin
          if (opcode == OP_WAIT) begin
            wait_start = 1'b1;
            nx_code    = (count_val == '0) ? RS_DONE : RS_BUSY;
          end else if (!hit_a) begin
            case (opcode)
              OP_FIQ_SET: t_arm[0] = 1'b1;
              OP_IRQ_SET: t_arm[1] = 1'b1;
              OP_FIQ_CLR: t_clr[0] = 1'b1;
              OP_IRQ_CLR: t_clr[1] = 1'b1;
              OP_STAMP: begin
                rf_we    = 1'b1;
                rf_waddr = cnt_idx;
                rf_wdata = cyc_cnt;
              end
              default: nx_code = RS_CANT;
            endcase
          end else begin
            nx_code = RS_CANT;
          end
        end
        default: nx_code = RS_CANT;
      endcase
    end else if (beat_valid && ls_open) begin
      nx_valid  = 1'b1;
      beat_take = 1'b1;
      nx_code   = beat_final ? RS_DONE : RS_INC;
      if (ls_load) begin
        rf_we    = 1'b1;
        rf_waddr = ls_idx;
        rf_wdata = beat_wdata;
      end else begin
        nx_rdata = rf_rdata_a;
      end
    end
  end

  // ---------------------------------------------------------------
  // Registered outputs, cycle counter, transfer tracking
  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= RS_DONE;
      resp_rdata <= '0;
      cyc_cnt    <= '0;
      ls_open    <= 1'b0;
      ls_load    <= 1'b0;
      ls_long    <= 1'b0;
      ls_idx     <= '0;
      beat_cnt   <= '0;
    end else begin
      resp_valid <= nx_valid;
      resp_code  <= nx_code;
      resp_rdata <= nx_rdata;
      cyc_cnt    <= cyc_cnt + 1'b1;
      if (ls_set) begin
        ls_open  <= 1'b1;
        ls_load  <= (kind == CK_LOAD);
        ls_long  <= cmd_instr[LONG_BIT];
        ls_idx   <= mem_idx;
        beat_cnt <= '0;
      end else if (beat_take) begin
        beat_cnt <= beat_cnt + 1'b1;
        if (beat_final) begin
          ls_open <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/valcop_checker.sv
module valcop_checker #(
  parameter logic [3:0] CP_A = 4'd4,
  parameter logic [3:0] CP_B = 4'd5
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_cp,
  input logic [2:0] cmd_kind,
  input logic [3:0] cmd_op,
  input logic       beat_valid,
  input logic       resp_valid,
  input logic [1:0] resp_code,
  input logic       fiq_n,
  input logic       irq_n,
  input logic       wait_busy
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: the cycle after a reset edge shows the quiet output state
  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_quiet_R1: assert (fiq_n && irq_n && !resp_valid)
        else $error("reset state violated");
    end
  end

  // R3: nothing addressed to this block and no wait in progress -> no response
  assert_silent_when_unaddressed_R3: assert property (@(posedge clk) disable iff (rst)
    (!wait_busy && !beat_valid && (!cmd_valid || (cmd_cp != CP_A && cmd_cp != CP_B)))
      |=> !resp_valid);

  // R5: an increment answer only ever follows a data beat
  assert_inc_after_beat_R5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code == 2'd1) |-> $past(beat_valid));

  // R6: load/store on number B is refused
  assert_ls_on_b_refused_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !wait_busy && cmd_cp == CP_B && cmd_cp != CP_A &&
     (cmd_kind == 3'd2 || cmd_kind == 3'd3))
      |=> (resp_valid && resp_code == 2'd3));

  // R7: a busy answer is followed by another busy or by done
  assert_busy_continues_R7: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code == 2'd2)
      |=> (resp_valid && (resp_code == 2'd2 || resp_code == 2'd0)));

  // R9: clearing the fast request raises its line on the next cycle
  assert_fiq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !wait_busy && cmd_cp == CP_B && cmd_cp != CP_A &&
     cmd_kind == 3'd4 && cmd_op == 4'd3) |=> fiq_n);

  // R11: number A refuses every data operation except the wait
  assert_a_refuses_ops_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !wait_busy && cmd_cp == CP_A && cmd_kind == 3'd4 && cmd_op != 4'd0)
      |=> (resp_valid && resp_code == 2'd3));

endmodule

bind valcop_top valcop_checker #(
  .CP_A(CP_A),
  .CP_B(CP_B)
) u_valcop_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_cp    (cmd_cp),
  .cmd_kind  (cmd_kind),
  .cmd_op    (cmd_instr[23:20]),
  .beat_valid(beat_valid),
  .resp_valid(resp_valid),
  .resp_code (resp_code),
  .fiq_n     (fiq_n),
  .irq_n     (irq_n),
  .wait_busy (wait_busy)
);

// File: tb/valcop_top_bench.sv
module valcop_top_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] CPA = 4'd4;
  localparam logic [3:0] CPB = 4'd5;
  localparam logic [3:0] CPX = 4'd7;
  localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_LD = 3'd2, K_ST = 3'd3, K_OP = 3'd4;
  // status word {valid, code}
  localparam logic [31:0] S_NONE = 32'h0, S_DONE = 32'h4, S_INC = 32'h5,
                          S_BUSY = 32'h6, S_CANT = 32'h7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_cp = '0;
  logic [2:0]  cmd_kind = '0;
  logic [31:0] cmd_instr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        beat_valid = 1'b0;
  logic [31:0] beat_wdata = '0;
  logic        resp_valid;
  logic [1:0]  resp_code;
  logic [31:0] resp_rdata;
  logic        fiq_n, irq_n;

  int n_run  = 0;
  int n_fail = 0;
  logic        r_v;
  logic [1:0]  r_c;
  logic [31:0] r_d;

  always #2.5 clk = ~clk;

  valcop_top u_valcop_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_cp(cmd_cp),
    .cmd_kind(cmd_kind), .cmd_instr(cmd_instr), .cmd_wdata(cmd_wdata),
    .beat_valid(beat_valid), .beat_wdata(beat_wdata),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_rdata(resp_rdata),
    .fiq_n(fiq_n), .irq_n(irq_n)
  );

  typedef struct packed {
    logic [3:0]  cp;
    logic [2:0]  kind;
    logic [31:0] instr;
    logic [31:0] wdata;
    logic [2:0]  exp_st;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic [7:0]  req;
  } vec_t;

  localparam int N_VEC = 17;
  localparam vec_t VECS [N_VEC] = '{
    '{CPA, K_WR, 32'h0003_0000, 32'hDEAD_BEEF, 3'd4, 1'b0, 32'h0,          8'd2},  // R2
    '{CPB, K_RD, 32'h0003_0000, 32'h0,         3'd4, 1'b1, 32'hDEAD_BEEF,  8'd2},  // R2
    '{CPB, K_WR, 32'h000F_0000, 32'h1234_5678, 3'd4, 1'b0, 32'h0,          8'd2},  // R2
    '{CPA, K_RD, 32'h000F_0000, 32'h0,         3'd4, 1'b1, 32'h1234_5678,  8'd2},  // R2
    '{CPX, K_WR, 32'h0003_0000, 32'h0,         3'd0, 1'b0, 32'h0,          8'd3},  // R3
    '{CPX, K_RD, 32'h0003_0000, 32'h0,         3'd0, 1'b0, 32'h0,          8'd3},  // R3
    '{CPA, K_RD, 32'h0003_0000, 32'h0,         3'd4, 1'b1, 32'hDEAD_BEEF,  8'd3},  // R3
    '{CPB, K_LD, 32'h0000_1000, 32'h0,         3'd7, 1'b0, 32'h0,          8'd6},  // R6
    '{CPB, K_ST, 32'h0000_1000, 32'h0,         3'd7, 1'b0, 32'h0,          8'd6},  // R6
    '{CPA, K_OP, 32'h0010_0000, 32'h0,         3'd7, 1'b0, 32'h0,          8'd11}, // R11
    '{CPA, K_OP, 32'h00F0_0000, 32'h0,         3'd7, 1'b0, 32'h0,          8'd11}, // R11
    '{CPB, K_OP, 32'h0060_0000, 32'h0,         3'd7, 1'b0, 32'h0,          8'd11}, // R11
    '{CPA, 3'd5, 32'h0000_0000, 32'h0,         3'd7, 1'b0, 32'h0,          8'd11}, // R11
    '{CPB, 3'd7, 32'h0000_0000, 32'h0,         3'd7, 1'b0, 32'h0,          8'd11}, // R11
    '{CPA, K_WR, 32'h0000_0000, 32'h0,         3'd4, 1'b0, 32'h0,          8'd7},  // R7 reg0 = 0
    '{CPA, K_OP, 32'h0000_0000, 32'h0,         3'd4, 1'b0, 32'h0,          8'd7},  // R7 zero wait on A
    '{CPB, K_OP, 32'h0000_0000, 32'h0,         3'd4, 1'b0, 32'h0,          8'd7}   // R7 zero wait on B
  };

  function automatic logic [31:0] st();
    return {29'd0, r_v, r_c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic sample();
    r_v = resp_valid;
    r_c = resp_code;
    r_d = resp_rdata;
  endtask

  // Called at a falling edge; returns at the next falling edge with the response
  task automatic issue(input logic [3:0] cp, input logic [2:0] k,
                       input logic [31:0] ins, input logic [31:0] wd);
    cmd_valid = 1'b1; cmd_cp = cp; cmd_kind = k; cmd_instr = ins; cmd_wdata = wd;
    @(negedge clk);
    sample();
    cmd_valid = 1'b0;
  endtask

  task automatic beat(input logic [31:0] d);
    beat_valid = 1'b1; beat_wdata = d;
    @(negedge clk);
    sample();
    beat_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    sample();
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] v);
    issue(CPA, K_WR, {12'h000, idx, 16'h0000}, v);
  endtask

  task automatic rd(input logic [3:0] idx);
    issue(CPB, K_RD, {12'h000, idx, 16'h0000}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int nb;
    logic [31:0] t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    sample();
    // R1 reset state
    check(!r_v && fiq_n && irq_n, "R1 outputs after reset",
          {29'd0, r_v, fiq_n, irq_n}, 32'h3);

    // Vector table
    for (int i = 0; i < N_VEC; i++) begin
      issue(VECS[i].cp, VECS[i].kind, VECS[i].instr, VECS[i].wdata);
      check(st() == {29'd0, VECS[i].exp_st}, $sformatf("R%0d vector %0d status", VECS[i].req, i),
            st(), {29'd0, VECS[i].exp_st});
      if (VECS[i].chk_rd)
        check(r_d == VECS[i].exp_rd, $sformatf("R%0d vector %0d data", VECS[i].req, i),
              r_d, VECS[i].exp_rd);
    end

    // R7: wait of four cycles on A, with a command ignored during it
    wr(4'd1, 32'd4);
    wr(4'd2, 32'h0000_AAAA);
    issue(CPA, K_OP, 32'h0000_0001, 32'h0);
    check(st() == S_BUSY, "R7 wait start busy", st(), S_BUSY);
    nb = 1;
    cmd_valid = 1'b1; cmd_cp = CPA; cmd_kind = K_WR; cmd_instr = 32'h0002_0000;
    cmd_wdata = 32'h0000_5555;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      sample();
      if (r_v && r_c == 2'd2) nb++;
      else break;
    end
    check(nb == 4, "R7 busy count", nb, 32'd4);
    check(st() == S_DONE, "R7 wait end done", st(), S_DONE);
    rd(4'd2);
    check(r_d == 32'h0000_AAAA, "R7 command during wait ignored", r_d, 32'h0000_AAAA);

    // R7: wait of two cycles on B
    wr(4'd8, 32'd2);
    issue(CPB, K_OP, 32'h0000_0008, 32'h0);
    nb = (st() == S_BUSY) ? 1 : 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sample();
      if (r_v && r_c == 2'd2) nb++;
      else break;
    end
    check(nb == 2 && st() == S_DONE, "R7 wait on B", nb, 32'd2);

    // R4: single-word load and store on register 6
    issue(CPA, K_LD, 32'h0000_6000, 32'h0);
    check(st() == S_DONE, "R4 load command", st(), S_DONE);
    beat(32'h0000_1111);
    check(st() == S_DONE, "R4 single load beat", st(), S_DONE);
    rd(4'd6);
    check(r_d == 32'h0000_1111, "R4 load data", r_d, 32'h0000_1111);
    issue(CPA, K_ST, 32'h0000_6000, 32'h0);
    beat(32'h0);
    check(st() == S_DONE && r_d == 32'h0000_1111, "R4 store beat", r_d, 32'h0000_1111);
    beat(32'h0);
    check(st() == S_NONE, "R5 beat with no open transfer", st(), S_NONE);

    // R5: long load, four increments then done, all to one register
    issue(CPA, K_LD, 32'h0040_6000, 32'h0);
    for (int i = 1; i <= 5; i++) begin
      beat(32'h100 + i);
      check(st() == ((i < 5) ? S_INC : S_DONE), $sformatf("R5 long load beat %0d", i),
            st(), (i < 5) ? S_INC : S_DONE);
    end
    beat(32'hFFFF);
    check(st() == S_NONE, "R5 beat after burst end", st(), S_NONE);
    rd(4'd6);
    check(r_d == 32'h105, "R5 same register last beat", r_d, 32'h105);

    // R5: restart of beat count by a new command
    issue(CPA, K_ST, 32'h0040_6000, 32'h0);
    beat(32'h0);
    beat(32'h0);
    issue(CPA, K_ST, 32'h0040_6000, 32'h0);
    nb = 0;
    for (int i = 1; i <= 5; i++) begin
      beat(32'h0);
      if (st() == S_INC) nb++;
    end
    check(nb == 4 && st() == S_DONE && r_d == 32'h105, "R5 restarted burst", nb, 32'd4);

    // R8: fast interrupt after three cycles
    wr(4'd4, 32'd3);
    issue(CPB, K_OP, 32'h0010_0004, 32'h0);
    check(st() == S_DONE && fiq_n, "R8 fiq armed, still high", {31'd0, fiq_n}, 32'h1);
    idle(2);
    check(fiq_n == 1'b1, "R8 fiq high before count", {31'd0, fiq_n}, 32'h1);
    idle(1);
    check(fiq_n == 1'b0 && irq_n == 1'b1, "R8 fiq low after count",
          {30'd0, fiq_n, irq_n}, 32'h1);

    // R9: clear fast request
    issue(CPB, K_OP, 32'h0030_0000, 32'h0);
    check(fiq_n == 1'b1, "R9 fiq cleared", {31'd0, fiq_n}, 32'h1);

    // R8: zero-count normal interrupt is immediate
    issue(CPB, K_OP, 32'h0020_0000, 32'h0);
    check(irq_n == 1'b0, "R8 irq immediate on zero", {31'd0, irq_n}, 32'h0);
    issue(CPB, K_OP, 32'h0040_0000, 32'h0);
    check(irq_n == 1'b1, "R9 irq cleared", {31'd0, irq_n}, 32'h1);

    // R8: independent countdowns (fiq 5, irq 2 issued one cycle later)
    wr(4'd5, 32'd5);
    wr(4'd7, 32'd2);
    issue(CPB, K_OP, 32'h0010_0005, 32'h0);
    issue(CPB, K_OP, 32'h0020_0007, 32'h0);
    idle(2);
    check(irq_n == 1'b0 && fiq_n == 1'b1, "R8 irq fires first",
          {30'd0, fiq_n, irq_n}, 32'h2);
    idle(2);
    check(fiq_n == 1'b0, "R8 fiq fires later", {31'd0, fiq_n}, 32'h0);
    issue(CPB, K_OP, 32'h0030_0000, 32'h0);
    issue(CPB, K_OP, 32'h0040_0000, 32'h0);

    // R9: clear leaves a pending countdown alive
    issue(CPB, K_OP, 32'h0010_0004, 32'h0);
    issue(CPB, K_OP, 32'h0030_0000, 32'h0);
    idle(2);
    check(fiq_n == 1'b0, "R9 pending fires after clear", {31'd0, fiq_n}, 32'h0);
    issue(CPB, K_OP, 32'h0030_0000, 32'h0);

    // R9: re-arm restarts the countdown
    issue(CPB, K_OP, 32'h0010_0004, 32'h0);
    issue(CPB, K_OP, 32'h0010_0004, 32'h0);
    idle(2);
    check(fiq_n == 1'b1, "R9 restart delays fire", {31'd0, fiq_n}, 32'h1);
    idle(1);
    check(fiq_n == 1'b0, "R9 restart fires", {31'd0, fiq_n}, 32'h0);

    // R10: two captures seven cycles apart
    issue(CPB, K_OP, 32'h0050_000A, 32'h0);
    check(st() == S_DONE, "R10 capture answer", st(), S_DONE);
    idle(6);
    issue(CPB, K_OP, 32'h0050_000B, 32'h0);
    rd(4'd10);
    t0 = r_d;
    rd(4'd11);
    check(r_d - t0 == 32'd7, "R10 capture difference", r_d - t0, 32'd7);

    // R1: reset mid-run clears a low line and a pending countdown
    issue(CPB, K_OP, 32'h0020_0005, 32'h0);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    check(fiq_n && irq_n && !r_v, "R1 reset clears lines",
          {29'd0, fiq_n, irq_n, r_v}, 32'h6);
    idle(8);
    check(irq_n == 1'b1, "R1 pending countdown cancelled", {31'd0, irq_n}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule